// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI bridge's configuration header. The bus protocol engine raises single-cycle event pulses when it sees a parity error, drives SERR, terminates a transaction with master-abort, receives a target-abort, or issues one. Each pulse latches a sticky flag. The flags stay set until configuration software clears them.

Software reads the whole word at any time. To clear flags, it writes ones to the positions it wants cleared, so a read-modify-write cannot lose an event that arrives in between. Capability bits and reserved bits always return fixed values. The parity-error-response enable comes from the command register as a plain input and gates the data-parity flag.

The bit positions follow the standard configuration header layout, because software decodes them.

Top module: `pci_cfg_status`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'h00A0. Every sticky flag is 0, bit 7 is 1 and bit 5 is 1.
- R2: A pulse on `evt_parity_err` sets bit 15 on the next clock edge, whatever the values of `perr_resp_en` and `evt_as_master`.
- R3: A pulse on `evt_serr` sets bit 14 on the next clock edge.
- R4: A pulse on `evt_master_abort` sets bit 13 on the next clock edge, unless `evt_special_cycle` is high in the same cycle. In that case bit 13 stays unchanged.
- R5: A pulse on `evt_tabort_rcvd` sets bit 12, and a pulse on `evt_tabort_sig` sets bit 11, each on the next clock edge.
- R6: Bit 8 sets only when `evt_parity_err`, `evt_as_master` and `perr_resp_en` are all high in the same cycle. If any one of them is low, bit 8 stays unchanged.
- R7: Bits 10:9 always read 0, bit 7 reads 1, bit 5 reads 1, and bits 6 and 4:0 read 0. Writes to these positions have no effect.
- R8: A write never sets a flag. A sticky bit (15, 14, 13, 12, 11 or 8) is cleared on the write's clock edge when its write-data bit is 1. A 0 in the write data leaves that bit unchanged.
- R9: Clearing needs the byte enable of the lane that holds the bit. `cfg_be[1]` covers bits 15:8 and `cfg_be[0]` covers bits 7:0. All sticky bits sit in lane 1, so a write with only `cfg_be[0]` set changes nothing.
- R10: If a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R11: `cfg_rdata` shows the register value from before any write in the same cycle. A write takes effect only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe for the status word |
| cfg_be | input | 2 | Byte enables: bit 1 for data[15:8], bit 0 for data[7:0] |
| cfg_wdata | input | 16 | Write data; ones clear the matching flags |
| cfg_rdata | output | 16 | Current status word |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| evt_parity_err | input | 1 | Address or data parity error detected (pulse) |
| evt_as_master | input | 1 | The bridge is master of the current transaction |
| evt_serr | input | 1 | The bridge drove SERR (pulse) |
| evt_master_abort | input | 1 | The bridge as master ended a transaction with master-abort (pulse) |
| evt_special_cycle | input | 1 | The current master-abort belongs to a special cycle |
| evt_tabort_rcvd | input | 1 | A bridge-initiated transaction was ended by target-abort (pulse) |
| evt_tabort_sig | input | 1 | The bridge as target issued a target-abort (pulse) |

## Verification
The assertions assume that each event input is a one-cycle pulse sampled at the rising edge. They also assume that `evt_as_master`, `evt_special_cycle` and `perr_resp_en` are valid in the same cycle as the pulse they qualify. The bench drives every input on the falling edge and releases event pulses on the next falling edge, so each event is seen by exactly one rising edge. The bench holds the qualifiers steady across that window and keeps the write strobe low whenever it is not deliberately checking a same-cycle collision.

// File: rtl/pci_cfg_status.sv
module pci_cfg_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_be,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         perr_resp_en,
  input  logic         evt_parity_err,
  input  logic         evt_as_master,
  input  logic         evt_serr,
  input  logic         evt_master_abort,
  input  logic         evt_special_cycle,
  input  logic         evt_tabort_rcvd,
  input  logic         evt_tabort_sig
);
  localparam logic [W-1:0] STICKY = 16'hF900;
  localparam logic [W-1:0] FIXED  = 16'h00A0;

  logic [W-1:0] flags;
  logic [W-1:0] set_vec, lane_mask, clr_vec;

  assign set_vec = {evt_parity_err, evt_serr, evt_master_abort & ~evt_special_cycle,
                    evt_tabort_rcvd, evt_tabort_sig, 2'b00,
                    evt_parity_err & evt_as_master & perr_resp_en, 8'h00};

  assign lane_mask = {{8{cfg_be[1]}}, {8{cfg_be[0]}}};
  assign clr_vec   = {W{cfg_wr}} & lane_mask & cfg_wdata & STICKY;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (set_vec | (flags & ~clr_vec)) & STICKY;

  assign cfg_rdata = flags | FIXED;

  assert_no_write_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !evt_parity_err && !evt_serr && !evt_master_abort &&
     !evt_tabort_rcvd && !evt_tabort_sig)
    |=> ((cfg_rdata & ~$past(cfg_rdata)) == '0));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be[1] && cfg_wdata[14] && !evt_serr) |=> !cfg_rdata[14]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_serr |=> cfg_rdata[14]);

  assert_parity_any_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_parity_err |=> cfg_rdata[15]);

  assert_dpd_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[8]) |-> $past(evt_parity_err && evt_as_master && perr_resp_en));

  assert_special_excluded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[13]) |-> $past(evt_master_abort && !evt_special_cycle));

  assert_low_lane_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_parity_err && !evt_serr && !evt_master_abort && !evt_tabort_rcvd &&
     !evt_tabort_sig && !(cfg_wr && cfg_be[1])) |=> $stable(cfg_rdata));
endmodule

// File: tb/pci_cfg_status_test.sv
module pci_cfg_status_test;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic perr_resp_en = 0, evt_parity_err = 0, evt_as_master = 0, evt_serr = 0;
  logic evt_master_abort = 0, evt_special_cycle = 0, evt_tabort_rcvd = 0, evt_tabort_sig = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_cfg_status uut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // ev = {parity, serr, master_abort, special, tabort_rcvd, tabort_sig, as_master}
  task automatic cyc(logic wr, logic [1:0] be, logic [15:0] d, logic [6:0] ev, logic en);
    @(negedge clk);
    cfg_wr = wr; cfg_be = be; cfg_wdata = d; perr_resp_en = en;
    {evt_parity_err, evt_serr, evt_master_abort, evt_special_cycle,
     evt_tabort_rcvd, evt_tabort_sig, evt_as_master} = ev;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    {evt_parity_err, evt_serr, evt_master_abort, evt_special_cycle,
     evt_tabort_rcvd, evt_tabort_sig, evt_as_master} = '0;
  endtask

  task automatic clear_all();
    cyc(1, 2'b11, 16'hFFFF, 7'b0, 0);
    chk("R8 clear all", cfg_rdata, 16'h00A0);
  endtask

  task automatic t_reset();
    chk("R1 reset value", cfg_rdata, 16'h00A0);
  endtask

  task automatic t_parity();
    cyc(0, 0, 0, 7'b1000001, 0);
    chk("R2 parity without enable, R6 no dpd", cfg_rdata, 16'h80A0);
    clear_all();
    cyc(0, 0, 0, 7'b1000001, 1);
    chk("R6 all three conditions", cfg_rdata, 16'h81A0);
    clear_all();
    cyc(0, 0, 0, 7'b1000000, 1);
    chk("R6 not master", cfg_rdata, 16'h80A0);
    clear_all();
  endtask

  task automatic t_events();
    cyc(0, 0, 0, 7'b0100000, 0);
    chk("R3 serr", cfg_rdata, 16'h40A0);
    clear_all();
    cyc(0, 0, 0, 7'b0011000, 0);
    chk("R4 special cycle excluded", cfg_rdata, 16'h00A0);
    cyc(0, 0, 0, 7'b0010000, 0);
    chk("R4 master abort", cfg_rdata, 16'h20A0);
    clear_all();
    cyc(0, 0, 0, 7'b0000100, 0);
    chk("R5 target abort received", cfg_rdata, 16'h10A0);
    clear_all();
    cyc(0, 0, 0, 7'b0000010, 0);
    chk("R5 target abort signalled", cfg_rdata, 16'h08A0);
    clear_all();
  endtask

  task automatic t_writes();
    cyc(0, 0, 0, 7'b0110110, 0);
    chk("R3 R4 R5 combined", cfg_rdata, 16'h78A0);
    @(negedge clk);
    cfg_wr = 1; cfg_be = 2'b10; cfg_wdata = 16'h2000;
    #1 chk("R11 pre-write read", cfg_rdata, 16'h78A0);
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    chk("R8 selective clear", cfg_rdata, 16'h58A0);
    cyc(1, 2'b01, 16'hFFFF, 7'b0, 0);
    chk("R9 low lane only", cfg_rdata, 16'h58A0);
    cyc(1, 2'b11, 16'h0000, 7'b0, 0);
    chk("R8 zeros keep bits", cfg_rdata, 16'h58A0);
    cyc(1, 2'b11, 16'hFFFF, 7'b0100000, 0);
    chk("R10 set beats clear", cfg_rdata, 16'h40A0);
    clear_all();
    cyc(1, 2'b11, 16'h06FF, 7'b0, 0);
    chk("R7 fixed bits unwritable", cfg_rdata, 16'h00A0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_parity();
    t_events();
    t_writes();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule